// File: doc/BRIEF.md
# Pulse-Frequency Buck Switch Sequencer

This block sequences the two power switches of a pulse-frequency-modulated buck regulator. Three analog detectors report to it as digital levels: a comparator that is high while the regulated output sits below its reference, a detector that fires when inductor current reaches its peak limit, and a detector that fires when inductor current falls to zero. The sequencer answers each low-output event with one switching cycle. The high-side switch charges the inductor until the peak is reached. One cycle of dead time follows, with both switches off. The low-side switch then discharges the inductor until the current reaches zero. Both switches then stay off until the comparator asks for energy again.

A programmable cycle limit bounds the high-side phase, so a peak detector that never fires cannot hold the high-side switch on. A regulate-enable input gates all switching. Two monitoring outputs are provided: a one-cycle pulse at the start of each switching cycle, and a flag that shows the last high-side phase was ended by the limit and not by the peak detector. All three detector inputs are resynchronized into the controller clock domain before they are used.

Top module: `pfm_buck_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after reset is released, `hs_on_o`, `ls_on_o`, `cyc_start_o` and `tmo_hit_o` are all low.
- R2: A switching cycle starts only when `regulate_i` is high and the synchronized `vout_low_i` is high. With `regulate_i` low, a high `vout_low_i` causes no switching and no start pulse.
- R3: Each detector input passes through two flops. If `ipk_i` rises during the Nth clock cycle in which `hs_on_o` is high, `hs_on_o` stays high for exactly N+2 cycles, unless the limit of R7 ends the phase earlier.
- R4: `hs_on_o` and `ls_on_o` are never high together. After `hs_on_o` falls there is exactly one clock cycle with both low before `ls_on_o` rises.
- R5: If `zcd_i` rises during the Mth cycle in which `ls_on_o` is high, `ls_on_o` stays high for exactly M+2 cycles and then falls.
- R6: After the low-side phase ends, both enables stay low for as long as the synchronized `vout_low_i` stays low.
- R7: The high-side phase lasts at most `tmo_cycles_i` clock cycles. A value of 0 is treated as 1.
- R8: `tmo_hit_o` goes high on the cycle after a high-side phase that the limit ended, and it is cleared when the next cycle starts. If the peak indication and the limit expiry arrive in the same cycle, the peak takes priority and `tmo_hit_o` stays low.
- R9: `cyc_start_o` is high for exactly one clock cycle per switching cycle, namely the first cycle in which `hs_on_o` is high.
- R10: When `regulate_i` goes low, both enables go low in the same cycle without waiting for a clock edge. The sequencer returns to idle at the next edge and then waits for a fresh comparator request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| regulate_i | input | 1 | Permits switching when high |
| vout_low_i | input | 1 | Comparator: output below reference (asynchronous) |
| ipk_i | input | 1 | Peak-current detector (asynchronous) |
| zcd_i | input | 1 | Zero-crossing detector (asynchronous) |
| tmo_cycles_i | input | TMO_W | Maximum high-side phase length in cycles (0 acts as 1) |
| hs_on_o | output | 1 | High-side (PFET) switch enable |
| ls_on_o | output | 1 | Low-side (NFET) switch enable |
| cyc_start_o | output | 1 | One-cycle pulse at the start of each switching cycle |
| tmo_hit_o | output | 1 | Last high-side phase was ended by the limit |

## Verification
The delicate case is a peak indication and a limit expiry that arrive in the same cycle. Both want to end the high-side phase, and only one may set the flag. The bench sweeps the peak arrival point against every small limit value, including 0. Some pairs in this sweep make the synchronized peak and the expiry coincide exactly, and other pairs fall one cycle on either side of that point. For every pair the bench checks the high-side phase length against min(N+2, max(limit,1)), and it expects the flag only when the limit is strictly shorter than N+2.

// File: rtl/pfm_pkg.sv
// Package: shared types for the PFM buck switch sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pfm_pkg;

    // Phases of one switching cycle; IDLE doubles as the both-off third phase.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HS   = 2'd1,
        PH_DEAD = 2'd2,
        PH_LS   = 2'd3
    } pfm_phase_e;

    // Index of each detector inside the synchronized detector vector.
    localparam int DET_VLOW = 0;
    localparam int DET_IPK  = 1;
    localparam int DET_ZCD  = 2;
    localparam int DET_N    = 3;

endpackage

// File: rtl/pfm_sync.sv
// Module: pfm_sync
// Resynchronizes a vector of asynchronous levels into the clk domain
// through a chain of STAGES flops per bit.
// Assumes: each bit is a slow level (no multi-bit coherency needed).
module pfm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                // Later stages: settle the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pfm_peak_timer.sv
// Module: pfm_peak_timer
// Counts cycles spent in the high-side phase and flags when the programmed
// limit is reached, so that the phase can end without a peak indication.
// Assumes: count_en_i is high exactly during high-side cycles; a limit of 0
// acts as 1.
module pfm_peak_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] last_idx;

    // Cycles already spent in the phase; cleared outside it, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!count_en_i)     cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Index of the last permitted cycle of the phase.
    always_comb begin
        if (limit_i == '0) last_idx = '0;
        else               last_idx = limit_i - 1'b1;
    end

    // The current cycle is the last one allowed.
    assign expired_o = count_en_i && (cnt_q >= last_idx);

endmodule

// File: rtl/pfm_phase_fsm.sv
// Module: pfm_phase_fsm
// Cycle sequencer: idle -> high-side -> dead -> low-side -> idle.
// Also registers the cycle-start pulse and the limit-hit flag.
// Assumes: detector inputs are already synchronized; run_i may drop at any
// time and forces idle at the next edge.
module pfm_phase_fsm
    import pfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       vlow_i,
    input  logic       peak_i,
    input  logic       zero_i,
    input  logic       expired_i,
    output pfm_phase_e phase_o,
    output logic       start_o,
    output logic       tmo_hit_o
);

    pfm_phase_e phase_q, phase_d;
    logic       start_q, tmo_q;
    logic       begin_cyc;
    logic       end_by_limit;

    // Next-phase decision from the current phase and the detector levels.
    always_comb begin
        phase_d = phase_q;
        if (!run_i) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (vlow_i)              phase_d = PH_HS;
                PH_HS:   if (peak_i || expired_i) phase_d = PH_DEAD;
                PH_DEAD:                          phase_d = PH_LS;
                PH_LS:   if (zero_i)              phase_d = PH_IDLE;
                default:                          phase_d = PH_IDLE;
            endcase
        end
    end

    assign begin_cyc    = run_i && (phase_q == PH_IDLE) && vlow_i;
    assign end_by_limit = run_i && (phase_q == PH_HS) && expired_i && !peak_i;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Start pulse: high during the first high-side cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= begin_cyc;
    end

    // Limit flag: set on a limit-ended phase, cleared at the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)            tmo_q <= 1'b0;
        else if (begin_cyc)    tmo_q <= 1'b0;
        else if (end_by_limit) tmo_q <= 1'b1;
    end

    assign phase_o   = phase_q;
    assign start_o   = start_q;
    assign tmo_hit_o = tmo_q;

endmodule

// File: rtl/pfm_buck_ctrl.sv
// Module: pfm_buck_ctrl (top)
// PFM buck switch sequencer: synchronizes the three detector levels, runs
// the phase FSM and the high-side cycle limit, and decodes the gate enables.
// Assumes: gate enables may be decoded combinationally from registered phase
// and regulate_i (so disable acts within the same cycle).
module pfm_buck_ctrl
    import pfm_pkg::*;
#(
    parameter int TMO_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             regulate_i,
    input  logic             vout_low_i,
    input  logic             ipk_i,
    input  logic             zcd_i,
    input  logic [TMO_W-1:0] tmo_cycles_i,
    output logic             hs_on_o,
    output logic             ls_on_o,
    output logic             cyc_start_o,
    output logic             tmo_hit_o
);

    logic [DET_N-1:0] det_raw;
    logic [DET_N-1:0] det_sync;
    pfm_phase_e       phase;
    logic             hs_phase;
    logic             expired;

    assign det_raw[DET_VLOW] = vout_low_i;
    assign det_raw[DET_IPK]  = ipk_i;
    assign det_raw[DET_ZCD]  = zcd_i;

    pfm_sync #(
        .WIDTH  (DET_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (det_raw),
        .sync_o  (det_sync)
    );

    assign hs_phase = (phase == PH_HS) && regulate_i;

    pfm_peak_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (hs_phase),
        .limit_i    (tmo_cycles_i),
        .expired_o  (expired)
    );

    pfm_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (regulate_i),
        .vlow_i    (det_sync[DET_VLOW]),
        .peak_i    (det_sync[DET_IPK]),
        .zero_i    (det_sync[DET_ZCD]),
        .expired_i (expired),
        .phase_o   (phase),
        .start_o   (cyc_start_o),
        .tmo_hit_o (tmo_hit_o)
    );

    // Gate decode, gated by regulate_i so disabling needs no clock edge.
    assign hs_on_o = hs_phase;
    assign ls_on_o = (phase == PH_LS) && regulate_i;

endmodule

// File: rtl/pfm_buck_ctrl_chk.sv
// Module: pfm_buck_ctrl_chk
// Port-level property checker for pfm_buck_ctrl, bound to every instance.
// Assumes: tmo_cycles_i is held steady during a high-side phase.
module pfm_buck_ctrl_chk #(
    parameter int TMO_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             regulate_i,
    input logic [TMO_W-1:0] tmo_cycles_i,
    input logic             hs_on_o,
    input logic             ls_on_o,
    input logic             cyc_start_o,
    input logic             tmo_hit_o
);

    logic [TMO_W:0] hs_run_q;
    logic [TMO_W:0] hs_cap;

    // Length of the current high-side run observed at the port.
    always_ff @(posedge clk) begin
        if (!rst_n)       hs_run_q <= '0;
        else if (hs_on_o) hs_run_q <= hs_run_q + 1'b1;
        else              hs_run_q <= '0;
    end

    assign hs_cap = (tmo_cycles_i == '0) ? {{TMO_W{1'b0}}, 1'b1}
                                         : {1'b0, tmo_cycles_i};

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));

    p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on_o) |-> !$past(hs_on_o));

    p_hs_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on_o |-> (hs_run_q < hs_cap));

    p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !regulate_i |=> (!hs_on_o && !ls_on_o) || regulate_i);

    p_start_with_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |-> hs_on_o || !regulate_i);

    p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o);

    p_flag_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |-> !tmo_hit_o);

endmodule

bind pfm_buck_ctrl pfm_buck_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .regulate_i   (regulate_i),
    .tmo_cycles_i (tmo_cycles_i),
    .hs_on_o      (hs_on_o),
    .ls_on_o      (ls_on_o),
    .cyc_start_o  (cyc_start_o),
    .tmo_hit_o    (tmo_hit_o)
);

// File: tb/pfm_buck_ctrl_bench.sv
// Bench: sweeps peak arrival, limit and zero-crossing arrival, plus reset,
// idle and disable cases, with expected values computed from the rules.
module pfm_buck_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int TW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          regulate = 1'b0;
    logic          vlow = 1'b0;
    logic          ipk = 1'b0;
    logic          zcd = 1'b0;
    logic [TW-1:0] tmo = 8'd4;
    logic          hs_on, ls_on, cyc_start, tmo_hit;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    pfm_buck_ctrl #(.TMO_W(TW), .SYNC_STAGES(2)) u_pfm_buck_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .regulate_i   (regulate),
        .vout_low_i   (vlow),
        .ipk_i        (ipk),
        .zcd_i        (zcd),
        .tmo_cycles_i (tmo),
        .hs_on_o      (hs_on),
        .ls_on_o      (ls_on),
        .cyc_start_o  (cyc_start),
        .tmo_hit_o    (tmo_hit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full switching cycle: peak at high-side cycle p, zero at low-side cycle z.
    task automatic run_cycle(input int t, input int p, input int z);
        int pc, nc, gap, pulses, bad, guard, tm, exp_p;
        tm     = (t == 0) ? 1 : t;
        exp_p  = (p + 2 < tm) ? p + 2 : tm;
        tmo    = t[TW-1:0];
        vlow   = 1'b1;
        guard  = 0;
        @(negedge clk);
        while (!hs_on && guard < 100) begin @(negedge clk); guard++; end
        chk(cyc_start == 1'b1, "R9 start pulse on first high-side cycle", cyc_start, 1);
        vlow   = 1'b0;
        pulses = 0;
        pc     = 1;
        bad    = 0;
        if (p == 1) ipk = 1'b1;
        guard  = 0;
        forever begin
            @(negedge clk);
            if (cyc_start) pulses++;
            if (hs_on && ls_on) bad++;
            if (!hs_on || guard > 1000) break;
            pc++;
            guard++;
            if (pc == p) ipk = 1'b1;
        end
        ipk = 1'b0;
        chk(pc == exp_p, "R3/R7 high-side length", pc, exp_p);
        chk(tmo_hit == (tm < p + 2), "R8 limit flag after high-side", tmo_hit, int'(tm < p + 2));
        gap   = 0;
        guard = 0;
        while (!ls_on && guard < 100) begin gap++; guard++; @(negedge clk); end
        chk(gap == 1, "R4 dead time cycles", gap, 1);
        nc    = 1;
        if (z == 1) zcd = 1'b1;
        guard = 0;
        forever begin
            @(negedge clk);
            if (cyc_start) pulses++;
            if (hs_on && ls_on) bad++;
            if (!ls_on || guard > 1000) break;
            nc++;
            guard++;
            if (nc == z) zcd = 1'b1;
        end
        zcd = 1'b0;
        chk(nc == z + 2, "R5 low-side length", nc, z + 2);
        repeat (8) begin
            @(negedge clk);
            if (hs_on || ls_on) bad++;
            if (cyc_start) pulses++;
        end
        chk(bad == 0, "R6/R4 both off in third phase, no overlap", bad, 0);
        chk(pulses == 0, "R9 only one start pulse per cycle", pulses, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk({hs_on, ls_on, cyc_start, tmo_hit} == 4'b0, "R1 outputs low in reset",
            {hs_on, ls_on, cyc_start, tmo_hit}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({hs_on, ls_on, cyc_start, tmo_hit} == 4'b0, "R1 outputs low after reset",
            {hs_on, ls_on, cyc_start, tmo_hit}, 0);

        // R2: comparator request while regulation is disabled does nothing.
        vlow = 1'b1;
        cnt  = 0;
        repeat (12) begin
            @(negedge clk);
            if (hs_on || ls_on || cyc_start) cnt++;
        end
        chk(cnt == 0, "R2 no switching while disabled", cnt, 0);
        vlow = 1'b0;
        repeat (4) @(negedge clk);
        regulate = 1'b1;
        cnt = 0;
        repeat (10) begin
            @(negedge clk);
            if (hs_on || ls_on) cnt++;
        end
        chk(cnt == 0, "R2 no switching without request", cnt, 0);

        // Sweep limit against peak arrival; the zero-crossing point varies too.
        for (int t = 0; t <= 9; t++) begin
            for (int p = 1; p <= 8; p++) begin
                run_cycle(t, p, 1 + (p % 3));
            end
        end

        // R10: disable in the middle of a high-side phase.
        tmo  = 8'd200;
        vlow = 1'b1;
        cnt  = 0;
        while (!hs_on && cnt < 100) begin @(negedge clk); cnt++; end
        vlow = 1'b0;
        repeat (3) @(negedge clk);
        regulate = 1'b0;
        #1;
        chk(!hs_on && !ls_on, "R10 enables drop without a clock edge", hs_on, 0);
        @(negedge clk);
        regulate = 1'b1;
        cnt = 0;
        repeat (8) begin
            @(negedge clk);
            if (hs_on || ls_on) cnt++;
        end
        chk(cnt == 0, "R10 back to idle after disable", cnt, 0);
        chk(!tmo_hit, "R8 disable does not set limit flag", tmo_hit, 0);

        // Normal cycle after the disable episode.
        run_cycle(5, 2, 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule